// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block turns one asynchronous serial line into characters. It uses a sample-enable strobe that runs at sixteen times the bit rate. A falling edge on the line starts a character. The receiver checks the start bit again near its middle, then samples each bit at its centre. It builds characters of 5 to 8 data bits, with an optional parity bit and one stop bit. For each character it gives a one-cycle valid strobe with the data and three flags: parity error, framing error and break.

Two line conditions get special handling. A frame that ends without a stop bit, with the line still low, is taken as the start of the next character. A line that stays low for the whole frame is a break. A break gives an all-zero character and a change-of-break pulse, and a second pulse when the line returns high.

The multidrop mode replaces parity with an address/data tag. In this mode reception goes on while the host has the receiver disabled, so that address characters still get through.

Top module: `serial_rx_brk`

## Requirements
- R1: `rxd` passes through two flip-flops. In idle, a high-to-low change of the synchronised line starts a character. The line is sampled again on the 8th `tick16` after that edge. If it is high there, the start is dropped and no character is produced.
- R2: After a valid start bit, each further bit is sampled every 16 ticks, least significant bit first. The length code `nbits` selects 0=5, 1=6, 2=7 or 3=8 data bits. Unused upper bits of `char_data` are zero.
- R3: `par_mode` selects 0=none, 1=even, 2=odd (3 is treated as none). When parity is used, a bit follows the data. `err_par` is 1 when that bit differs from the parity computed from the received data.
- R4: A high stop bit produces `char_vld` for exactly one cycle with `err_frm`=0. The search for the next start edge resumes at once.
- R5: A low stop bit on a frame that is not a break sets `err_frm`=1. If the line is still low 8 ticks after the stop sample, that point is treated as a new start edge. If the line is high there, the receiver goes back to idle.
- R6: If the line is low for the whole frame (data, parity or tag bit, and stop), one character is delivered with `char_data`=0, `brk_flag`=1, `err_frm`=0 and `err_par`=0. `brk_chg` pulses for one cycle in the same cycle.
- R7: After a break, the end of the break is recognised only once the synchronised line has been high on two successive `clk` edges. The end gives one more `brk_chg` pulse and no character. A high of one cycle only does not end the break.
- R8: With `multidrop`=1, one address/data tag bit follows the data in place of parity, whatever `par_mode` says. The tag is reported on `err_par`.
- R9: With `multidrop`=1 and `rx_en`=0, reception continues. Characters with tag 1 are delivered, tag-0 characters are discarded, and breaks are still reported. With `rx_en`=1, every character is delivered.
- R10: With `multidrop`=0 and `rx_en`=0, any character in progress is abandoned at once and nothing is delivered. After re-enabling, the receiver waits for a fresh start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial data line, idle high |
| rx_en | input | 1 | Receiver enable |
| multidrop | input | 1 | Address/data tag mode |
| nbits | input | 2 | Data length code (5 to 8 bits) |
| par_mode | input | 2 | Parity select |
| char_vld | output | 1 | One-cycle character strobe |
| char_data | output | 8 | Received character, zero-filled |
| err_par | output | 1 | Parity error, or the tag in multidrop mode |
| err_frm | output | 1 | Framing error |
| brk_flag | output | 1 | Character is a break |
| brk_chg | output | 1 | Break began or ended |

## Verification
The hardest cases to reach from the ports are the framing-error restart and the break exit. The restart needs a low stop bit with the line held low across the half-bit check, followed by a second character that is aligned to that check rather than to a real edge. The bench builds this as one continuous bit stream: bad frame, an extra low bit, then a clean frame. It expects two characters. The break test holds the line low for many bit times and injects a one-cycle high glitch, which must not end the break. It then releases the line and expects exactly one further change pulse. Random frames vary the length, the parity mode, the data and deliberately wrong parity bits.

// File: rtl/serial_rx_brk.sv
module serial_rx_brk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       multidrop,
  input  logic [1:0] nbits,
  input  logic [1:0] par_mode,
  output logic       char_vld,
  output logic [7:0] char_data,
  output logic       err_par,
  output logic       err_frm,
  output logic       brk_flag,
  output logic       brk_chg
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_FRST, S_BRK} st_t;

  st_t        st;
  logic [2:0] sync;
  logic [3:0] cnt;
  logic [2:0] idx;
  logic [7:0] dat;
  logic       pb;
  logic       hi1;

  wire       rxs      = sync[1];
  wire       fall     = sync[2] & ~sync[1];
  wire       active   = rx_en | multidrop;
  wire       has_pb   = multidrop | (par_mode == 2'd1) | (par_mode == 2'd2);
  wire [2:0] last_idx = {1'b0, nbits} + 3'd4;
  wire       mid      = tick16 && cnt == 4'd15;
  wire       half     = tick16 && cnt == 4'd7;
  wire       exp_par  = (^dat) ^ (par_mode == 2'd2);
  wire       deliver  = rx_en | ~multidrop | pb;
  wire       perr     = multidrop ? pb : (has_pb && pb != exp_par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sync      <= 3'b111;
      cnt       <= '0;
      idx       <= '0;
      dat       <= '0;
      pb        <= 1'b0;
      hi1       <= 1'b0;
      char_vld  <= 1'b0;
      char_data <= '0;
      err_par   <= 1'b0;
      err_frm   <= 1'b0;
      brk_flag  <= 1'b0;
      brk_chg   <= 1'b0;
    end else begin
      sync     <= {sync[1:0], rxd};
      char_vld <= 1'b0;
      brk_chg  <= 1'b0;
      if (tick16) cnt <= cnt + 4'd1;
      if (!active) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (fall) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (half) begin
            cnt <= '0;
            if (rxs) st <= S_IDLE;
            else begin
              st  <= S_DATA;
              idx <= '0;
              dat <= '0;
              pb  <= 1'b0;
            end
          end
          S_DATA: if (mid) begin
            dat[idx] <= rxs;
            idx      <= idx + 3'd1;
            if (idx == last_idx) st <= has_pb ? S_PAR : S_STOP;
          end
          S_PAR: if (mid) begin
            pb <= rxs;
            st <= S_STOP;
          end
          S_STOP: if (mid) begin
            cnt <= '0;
            if (!rxs && dat == 8'd0 && !pb) begin
              char_vld  <= 1'b1;
              char_data <= '0;
              err_par   <= 1'b0;
              err_frm   <= 1'b0;
              brk_flag  <= 1'b1;
              brk_chg   <= 1'b1;
              hi1       <= 1'b0;
              st        <= S_BRK;
            end else begin
              if (deliver) begin
                char_vld  <= 1'b1;
                char_data <= dat;
                err_par   <= perr;
                err_frm   <= ~rxs;
                brk_flag  <= 1'b0;
              end
              st <= rxs ? S_IDLE : S_FRST;
            end
          end
          S_FRST: if (half) begin
            cnt <= '0;
            st  <= rxs ? S_IDLE : S_START;
          end
          S_BRK: begin
            hi1 <= rxs;
            if (rxs && hi1) begin
              brk_chg <= 1'b1;
              st      <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       multidrop,
  input logic [1:0] nbits,
  input logic       char_vld,
  input logic [7:0] char_data,
  input logic       err_par,
  input logic       err_frm,
  input logic       brk_flag,
  input logic       brk_chg
);
  // R6
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && brk_flag) |-> (char_data == 8'd0 && !err_frm && brk_chg));
  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |=> !char_vld);
  // R7
  chg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_chg |=> !brk_chg);
  // R2
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && nbits == 2'd0) |-> char_data[7:5] == 3'd0);
  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !multidrop) |=> !char_vld);
  // R9
  tag_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && multidrop) |=> (!char_vld || brk_flag || err_par));
endmodule

bind serial_rx_brk serial_rx_brk_chk u_chk (.*);

// File: tb/sim_serial_rx_brk.sv
module sim_serial_rx_brk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic       multidrop = 1'b0;
  logic [1:0] nbits = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic       char_vld, err_par, err_frm, brk_flag, brk_chg;
  logic [7:0] char_data;

  int checks = 0, fails = 0;
  int ncap = 0, nchg = 0;
  logic [7:0] cd [4];
  logic       cp [4];
  logic       cf [4];
  logic       cb [4];
  logic [1:0] tdiv = 2'd0;

  serial_rx_brk u0 (.*);

  always #10 clk = ~clk;
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd2);
  end

  always @(negedge clk) begin
    if (char_vld) begin
      if (ncap < 4) begin
        cd[ncap] = char_data; cp[ncap] = err_par;
        cf[ncap] = err_frm;   cb[ncap] = brk_flag;
      end
      ncap = ncap + 1;
    end
    if (brk_chg) nchg = nchg + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bitt(input logic v);
    @(negedge clk) rxd = v;
    repeat (63) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input int nb, input bit hp,
                       input bit pv, input bit sv);
    bitt(1'b0);
    for (int i = 0; i < nb; i++) bitt(d[i]);
    if (hp) bitt(pv);
    bitt(sv);
  endtask

  function automatic logic [7:0] mask(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  function automatic bit pbit(input logic [7:0] d, input int pm);
    return (pm == 2) ? ~(^d) : (^d);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk("R4 reset vld", char_vld, 0);
    chk("R7 reset chg", brk_chg, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (70) @(negedge clk);

    // R2 R3 R4 random frames
    for (int n = 0; n < 50; n++) begin
      int nb = 5 + int'($urandom % 4);
      int pm = int'($urandom % 3);
      logic [7:0] d = 8'($urandom);
      bit bad = ($urandom % 4) == 0;
      logic [7:0] dm = mask(d, nb);
      nbits = 2'(nb - 5); par_mode = 2'(pm);
      ncap = 0;
      frame(d, nb, pm != 0, pbit(dm, pm) ^ bad, 1'b1);
      bitt(1'b1);
      chk("R4 count", ncap, 1);
      chk("R2 data", cd[0], dm);
      chk("R3 parity flag", cp[0], (pm != 0 && bad) ? 1 : 0);
      chk("R4 frm clear", cf[0], 0);
    end

    nbits = 2'd3; par_mode = 2'd0;
    // R1 false start
    ncap = 0;
    @(negedge clk) rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (128) @(negedge clk);
    chk("R1 false start dropped", ncap, 0);

    // R5 restart on low line
    ncap = 0;
    frame(8'hA5, 8, 0, 0, 1'b0);
    frame(8'h3C, 8, 0, 0, 1'b1);
    bitt(1'b1); bitt(1'b1);
    chk("R5 restart count", ncap, 2);
    chk("R5 first frm", cf[0], 1);
    chk("R5 first data", cd[0], 8'hA5);
    chk("R5 second data", cd[1], 8'h3C);
    chk("R5 second frm", cf[1], 0);

    // R5 no restart when line high
    ncap = 0;
    frame(8'h5A, 8, 0, 0, 1'b0);
    bitt(1'b1); bitt(1'b1); bitt(1'b1);
    chk("R5 single frm count", ncap, 1);
    chk("R5 single frm flag", cf[0], 1);

    // R6 R7 break
    ncap = 0; nchg = 0; par_mode = 2'd1;
    @(negedge clk) rxd = 1'b0;
    repeat (64 * 15) @(negedge clk);
    chk("R6 break count", ncap, 1);
    chk("R6 break data", cd[0], 0);
    chk("R6 break flag", cb[0], 1);
    chk("R6 break parity", cp[0], 0);
    chk("R6 entry pulse", nchg, 1);
    rxd = 1'b1;
    @(negedge clk) rxd = 1'b0;
    repeat (64) @(negedge clk);
    chk("R7 glitch ignored", nchg, 1);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    chk("R7 exit pulse", nchg, 2);
    chk("R7 no exit char", ncap, 1);
    par_mode = 2'd0;

    // R10 disable mid-character
    ncap = 0;
    bitt(1'b0); bitt(1'b1); bitt(1'b0);
    @(negedge clk) rx_en = 1'b0;
    for (int i = 0; i < 12; i++) bitt(1'b1);
    chk("R10 nothing while off", ncap, 0);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);
    frame(8'h81, 8, 0, 0, 1'b1);
    bitt(1'b1);
    chk("R10 count after re-enable", ncap, 1);
    chk("R10 data after re-enable", cd[0], 8'h81);

    // R8 R9 multidrop
    multidrop = 1'b1; rx_en = 1'b0; nbits = 2'd2; par_mode = 2'd1;
    ncap = 0;
    frame(8'h41, 7, 1, 1'b1, 1'b1); bitt(1'b1);
    chk("R9 address kept count", ncap, 1);
    chk("R8 address data", cd[0], 8'h41);
    chk("R8 tag on err_par", cp[0], 1);
    ncap = 0;
    frame(8'h42, 7, 1, 1'b0, 1'b1); bitt(1'b1);
    chk("R9 data dropped while off", ncap, 0);
    rx_en = 1'b1; ncap = 0;
    frame(8'h43, 7, 1, 1'b0, 1'b1); bitt(1'b1);
    chk("R9 data kept while on", ncap, 1);
    chk("R8 data tag zero", cp[0], 0);
    chk("R8 data value", cd[0], 8'h43);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule